// File: doc/BRIEF.md
# Load-Reserve Store-Conditional Tracker

This block keeps the reservation state that a bus bridge needs in order to serve load-reserve and store-conditional operations for up to four single-threaded cores. Each core owns one reservation: a valid flag and the tag of a 32-byte aligned granule, that is, address bits 31 down to 5. A load-reserve from a core writes that core's reservation. It does so in the cycle the command is accepted, before any reload data returns. A store-conditional from a core is judged against that core's own reservation and reports pass or fail one cycle later.

Every write that actually reaches memory snoops the reservations of all the other cores and invalidates those that name the same granule. A write here means a plain store or a store-conditional that passes. The bridge front end decodes commands and presents one command slot per core each cycle. Each slot carries a valid strobe, a two-bit operation and a 32-bit address. The tracker never issues back-invalidates to the cores. When a reserved line hits in a core's own cache, that core drops the line itself.

Top module: `resv_tracker`

## Requirements
- R1: Only address bits 31:5 take part in a comparison, so two addresses that differ only in bits 4:0 name the same granule. `rsv_tag` shows bits 31:5 of the reserving address.
- R2: A load-reserve (op 2'b01) sets the issuing core's reservation valid with the new granule tag, visible on `rsv_vld`/`rsv_tag` the cycle after acceptance. It replaces any older reservation of that core.
- R3: A store-conditional (op 2'b11) passes only if the issuing core's reservation is valid and its tag equals the granule of the store-conditional address.
- R4: After any store-conditional, passing or failing, the issuing core's reservation is invalid.
- R5: A plain store (op 2'b10) or a passing store-conditional from one core invalidates every other core's valid reservation on that granule in the same cycle. A core's own plain store leaves its own reservation alone, and a failing store-conditional invalidates nothing of any other core.
- R6: If a load-reserve and a write (R5) to the same granule from different cores arrive in the same cycle, the invalidation wins and the load-reserving core ends with no valid reservation.
- R7: A store-conditional fails if a plain store from another core hits its granule in the same cycle. When several store-conditionals to one granule would pass together, only the one from the lowest-numbered core passes.
- R8: The result of a store-conditional appears on `rsp_vld[c]` (high) and `rsp_pass[c]` exactly one cycle after acceptance. `rsp_vld[c]` is low in every cycle that does not follow a store-conditional from core c.
- R9: A synchronous reset clears all reservation valid flags, the tags and both response vectors.
- R10: A plain load (op 2'b00), or any slot whose `cmd_vld` is low, changes no state and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_vld | input | NUM_CORES | Per-core command strobe |
| cmd_op | input | 2*NUM_CORES | Per-core operation, core c in bits [2c+1:2c] |
| cmd_addr | input | 32*NUM_CORES | Per-core byte address, core c in bits [32c+31:32c] |
| rsv_vld | output | NUM_CORES | Reservation valid per core |
| rsv_tag | output | 27*NUM_CORES | Reserved granule (address bits 31:5) per core |
| rsp_vld | output | NUM_CORES | Store-conditional result valid per core |
| rsp_pass | output | NUM_CORES | Store-conditional passed per core |

## Verification
Directed sequences first cover the lone operations: reserve, then store-conditional to the same granule with different low bits, and store-conditional to a neighbouring granule. Together these show whether bits 4:0 are masked and whether bit 5 counts. Cross-core patterns follow. A foreign store must clear the reservation, an own store must not, and a failing store-conditional must not clear anything, which tells the snoop apart from blanket clearing. Same-cycle collisions of load-reserve against store and of store-conditional against store-conditional pin down priority and lowest-core-wins ordering. A long random phase over only four granules then forces frequent overlaps of all operations on every core, checked each clock against a behavioural model.

// File: rtl/resv_pkg.sv
package resv_pkg;

    localparam int RP_ADDR_W   = 32;
    localparam int RP_GRAN_LSB = 5;
    localparam int RP_TAG_W    = RP_ADDR_W - RP_GRAN_LSB;
    localparam int RP_OP_W     = 2;

    typedef enum logic [RP_OP_W-1:0] {
        OP_LOAD  = 2'b00,
        OP_LARX  = 2'b01,
        OP_STORE = 2'b10,
        OP_STCX  = 2'b11
    } op_e;

    typedef struct packed {
        logic                vld;
        logic [RP_TAG_W-1:0] tag;
        logic                rsp_vld;
        logic                rsp_pass;
    } slot_t;

endpackage

// File: rtl/resv_snoop.sv
module resv_snoop
    import resv_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES-1:0]               is_larx,
    input  logic [NUM_CORES-1:0]               is_store,
    input  logic [NUM_CORES-1:0]               is_stcx,
    input  logic [NUM_CORES-1:0][RP_TAG_W-1:0] gran,
    input  logic [NUM_CORES-1:0]               cur_vld,
    input  logic [NUM_CORES-1:0][RP_TAG_W-1:0] cur_tag,
    output logic [NUM_CORES-1:0]               stcx_pass,
    output logic [NUM_CORES-1:0]               larx_blk,
    output logic [NUM_CORES-1:0]               kill
);

    logic [NUM_CORES-1:0] raw_hit;
    logic [NUM_CORES-1:0] pass_d;
    logic [NUM_CORES-1:0] wr_d;
    logic [NUM_CORES-1:0] blk_d;
    logic [NUM_CORES-1:0] kill_d;

    always_comb begin
        raw_hit = '0;
        pass_d  = '0;
        wr_d    = '0;
        blk_d   = '0;
        kill_d  = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            raw_hit[i] = is_stcx[i] && cur_vld[i] && (cur_tag[i] == gran[i]);
        end
        for (int i = 0; i < NUM_CORES; i++) begin
            pass_d[i] = raw_hit[i];
            for (int j = 0; j < NUM_CORES; j++) begin
                if (j != i && gran[j] == gran[i]) begin
                    if (is_store[j]) pass_d[i] = 1'b0;
                    if (j < i && raw_hit[j]) pass_d[i] = 1'b0;
                end
            end
        end
        wr_d = is_store | pass_d;
        for (int i = 0; i < NUM_CORES; i++) begin
            for (int j = 0; j < NUM_CORES; j++) begin
                if (j != i && wr_d[j]) begin
                    if (gran[j] == gran[i] && is_larx[i]) blk_d[i] = 1'b1;
                    if (gran[j] == cur_tag[i] && cur_vld[i]) kill_d[i] = 1'b1;
                end
            end
        end
    end

    assign stcx_pass = pass_d;
    assign larx_blk  = blk_d;
    assign kill      = kill_d;

endmodule

// File: rtl/resv_slot.sv
module resv_slot
    import resv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                is_larx,
    input  logic                is_stcx,
    input  logic [RP_TAG_W-1:0] gran,
    input  logic                larx_blk,
    input  logic                kill,
    input  logic                stcx_pass,
    output logic                rvld,
    output logic [RP_TAG_W-1:0] rtag,
    output logic                rsp_vld,
    output logic                rsp_pass
);

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d          = slot_q;
        slot_d.rsp_vld  = is_stcx;
        slot_d.rsp_pass = is_stcx && stcx_pass;
        if (is_larx) begin
            slot_d.tag = gran;
            slot_d.vld = !larx_blk;
        end else if (is_stcx) begin
            slot_d.vld = 1'b0;
        end else if (kill) begin
            slot_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign rvld     = slot_q.vld;
    assign rtag     = slot_q.tag;
    assign rsp_vld  = slot_q.rsp_vld;
    assign rsp_pass = slot_q.rsp_pass;

    // R4: own reservation gone after any store-conditional
    a_r4_stcx_drops: assert property (@(posedge clk) disable iff (rst)
        is_stcx |=> !rvld);

    // R2: unblocked load-reserve installs the new granule
    a_r2_larx_takes: assert property (@(posedge clk) disable iff (rst)
        (is_larx && !larx_blk) |=> (rvld && rtag == $past(gran)));

    // R8: response strobe tracks the store-conditional one cycle later
    a_r8_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        is_stcx |=> rsp_vld);
    a_r8_rsp_quiet: assert property (@(posedge clk) disable iff (rst)
        !is_stcx |=> !rsp_vld);

    // R9: reset empties the slot
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!rvld && !rsp_vld && !rsp_pass));

endmodule

// File: rtl/resv_tracker.sv
module resv_tracker
    import resv_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CORES-1:0]          cmd_vld,
    input  logic [RP_OP_W*NUM_CORES-1:0]  cmd_op,
    input  logic [RP_ADDR_W*NUM_CORES-1:0] cmd_addr,
    output logic [NUM_CORES-1:0]          rsv_vld,
    output logic [RP_TAG_W*NUM_CORES-1:0] rsv_tag,
    output logic [NUM_CORES-1:0]          rsp_vld,
    output logic [NUM_CORES-1:0]          rsp_pass
);

    logic [NUM_CORES-1:0]               is_larx, is_store, is_stcx;
    logic [NUM_CORES-1:0][RP_TAG_W-1:0] gran;
    logic [NUM_CORES-1:0][RP_TAG_W-1:0] cur_tag;
    logic [NUM_CORES-1:0]               cur_vld;
    logic [NUM_CORES-1:0]               stcx_pass, larx_blk, kill;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
        logic [RP_OP_W-1:0] op_c;
        assign op_c        = cmd_op[c*RP_OP_W +: RP_OP_W];
        assign is_larx[c]  = cmd_vld[c] && (op_c == OP_LARX);
        assign is_store[c] = cmd_vld[c] && (op_c == OP_STORE);
        assign is_stcx[c]  = cmd_vld[c] && (op_c == OP_STCX);
        assign gran[c]     = cmd_addr[c*RP_ADDR_W + RP_GRAN_LSB +: RP_TAG_W];
    end

    resv_snoop #(.NUM_CORES(NUM_CORES)) u_snoop (
        .is_larx   (is_larx),
        .is_store  (is_store),
        .is_stcx   (is_stcx),
        .gran      (gran),
        .cur_vld   (cur_vld),
        .cur_tag   (cur_tag),
        .stcx_pass (stcx_pass),
        .larx_blk  (larx_blk),
        .kill      (kill)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
        resv_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .is_larx   (is_larx[c]),
            .is_stcx   (is_stcx[c]),
            .gran      (gran[c]),
            .larx_blk  (larx_blk[c]),
            .kill      (kill[c]),
            .stcx_pass (stcx_pass[c]),
            .rvld      (cur_vld[c]),
            .rtag      (cur_tag[c]),
            .rsp_vld   (rsp_vld[c]),
            .rsp_pass  (rsp_pass[c])
        );
        assign rsv_vld[c]                     = cur_vld[c];
        assign rsv_tag[c*RP_TAG_W +: RP_TAG_W] = cur_tag[c];

        // R3: a pass needs a reservation held in the accepting cycle
        a_r3_pass_needs_resv: assert property (@(posedge clk) disable iff (rst)
            rsp_pass[c] |-> (rsp_vld[c] && $past(cur_vld[c])));

        for (genvar o = 0; o < NUM_CORES; o++) begin : g_pair
            if (o != c) begin : g_other
                // R6: a same-cycle foreign store beats the load-reserve
                a_r6_store_beats_larx: assert property (@(posedge clk) disable iff (rst)
                    (is_larx[c] && is_store[o] && gran[o] == gran[c]) |=> !rsv_vld[c]);
                // R5: a foreign store drops a matching reservation
                a_r5_foreign_store_kills: assert property (@(posedge clk) disable iff (rst)
                    (is_store[o] && cur_vld[c] && gran[o] == cur_tag[c] && !is_larx[c])
                    |=> !rsv_vld[c]);
            end
        end
    end

endmodule

// File: tb/sim_resv_tracker.sv
`timescale 1ns/1ps
module sim_resv_tracker;

    localparam int N = 4;
    localparam int TW = 27;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    cmd_vld;
    logic [2*N-1:0]  cmd_op;
    logic [32*N-1:0] cmd_addr;
    logic [N-1:0]    rsv_vld;
    logic [TW*N-1:0] rsv_tag;
    logic [N-1:0]    rsp_vld;
    logic [N-1:0]    rsp_pass;

    always #4 clk = ~clk;

    resv_tracker #(.NUM_CORES(N)) u0 (
        .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .rsv_vld(rsv_vld), .rsv_tag(rsv_tag),
        .rsp_vld(rsp_vld), .rsp_pass(rsp_pass)
    );

    int errors = 0;
    int checks = 0;
    string cur_req = "R9";

    // stimulus staging
    logic        b_v[N];
    logic [1:0]  b_op[N];
    logic [31:0] b_a[N];

    // reference model
    logic        m_v[N];
    logic [26:0] m_t[N];
    logic        m_rv[N];
    logic        m_rp[N];

    task automatic clear_in();
        for (int i = 0; i < N; i++) begin
            b_v[i] = 1'b0; b_op[i] = 2'b00; b_a[i] = 32'h0;
        end
    endtask

    task automatic put(input int c, input logic [1:0] op, input logic [31:0] a);
        b_v[c] = 1'b1; b_op[c] = op; b_a[c] = a;
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            cmd_vld[i]        = b_v[i];
            cmd_op[2*i +: 2]  = b_op[i];
            cmd_addr[32*i +: 32] = b_a[i];
        end
    endtask

    task automatic model_step();
        logic [26:0] g[N];
        logic raw[N], pass[N], wr[N], st[N], lx[N], sc[N];
        logic nv[N];
        logic [26:0] nt[N];
        for (int i = 0; i < N; i++) begin
            g[i]  = b_a[i][31:5];
            lx[i] = b_v[i] && b_op[i] == 2'b01;
            st[i] = b_v[i] && b_op[i] == 2'b10;
            sc[i] = b_v[i] && b_op[i] == 2'b11;
            raw[i] = sc[i] && m_v[i] && m_t[i] == g[i];
        end
        for (int i = 0; i < N; i++) begin
            pass[i] = raw[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && st[j] && g[j] == g[i]) pass[i] = 1'b0;
                if (j < i && raw[j] && g[j] == g[i]) pass[i] = 1'b0;
            end
            wr[i] = 1'b0;
        end
        for (int i = 0; i < N; i++) wr[i] = st[i] || pass[i];
        for (int i = 0; i < N; i++) begin
            nv[i] = m_v[i]; nt[i] = m_t[i];
            if (lx[i]) begin
                nt[i] = g[i]; nv[i] = 1'b1;
                for (int j = 0; j < N; j++)
                    if (j != i && wr[j] && g[j] == g[i]) nv[i] = 1'b0;
            end else if (sc[i]) begin
                nv[i] = 1'b0;
            end else begin
                for (int j = 0; j < N; j++)
                    if (j != i && wr[j] && g[j] == m_t[i]) nv[i] = 1'b0;
            end
        end
        for (int i = 0; i < N; i++) begin
            m_v[i] = nv[i]; m_t[i] = nt[i];
            m_rv[i] = sc[i]; m_rp[i] = pass[i];
        end
    endtask

    task automatic chk(input string what, input int c, input logic [26:0] act, input logic [26:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s core%0d actual=%h expected=%h at %0t", cur_req, what, c, act, exp, $time);
        end
    endtask

    task automatic compare();
        for (int i = 0; i < N; i++) begin
            chk("rsv_vld", i, {26'd0, rsv_vld[i]}, {26'd0, m_v[i]});
            chk("rsv_tag", i, rsv_tag[TW*i +: TW], m_t[i]);
            chk("rsp_vld", i, {26'd0, rsp_vld[i]}, {26'd0, m_rv[i]});
            chk("rsp_pass", i, {26'd0, rsp_pass[i]}, {26'd0, m_rp[i]});
        end
    endtask

    // one cycle: inputs staged at negedge, compared after the edge
    task automatic tick();
        drive();
        if (!rst) model_step();
        @(posedge clk);
        #1;
        compare();
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_in();
        drive();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_t[i] = '0; m_rv[i] = 1'b0; m_rp[i] = 1'b0;
        end
        // R9: reset state, with commands presented during reset
        cur_req = "R9";
        @(negedge clk);
        put(0, 2'b01, 32'h0000_1000);
        tick();
        tick();
        rst = 1'b0;
        tick();

        // R10: plain loads and strobe-low slots do nothing
        cur_req = "R10";
        for (int i = 0; i < N; i++) put(i, 2'b00, 32'h0000_1000);
        tick();
        b_v[1] = 1'b0; b_op[1] = 2'b11; b_a[1] = 32'h0000_1000;
        tick();

        // R2: reserve and replace
        cur_req = "R2";
        put(0, 2'b01, 32'h0000_1000); put(1, 2'b01, 32'h0000_2040);
        tick();
        put(0, 2'b01, 32'h0000_3000);
        tick();

        // R10: after reservations exist, loads and idle strobes leave them
        cur_req = "R10";
        put(0, 2'b00, 32'h0000_3000); put(1, 2'b00, 32'h0000_2040);
        tick();

        // R1: low bits ignored, bit 5 significant
        cur_req = "R1";
        put(0, 2'b11, 32'h0000_301F); put(1, 2'b11, 32'h0000_2060);
        tick();
        tick();

        // R3 / R4: stcx without reservation fails, state stays empty
        cur_req = "R3";
        put(2, 2'b11, 32'h0000_3000);
        tick();
        cur_req = "R4";
        put(3, 2'b01, 32'h0000_8000);
        tick();
        put(3, 2'b11, 32'h0000_9000);
        tick();

        // R5: foreign store kills both matching reservations
        cur_req = "R5";
        put(2, 2'b01, 32'h0000_4000); put(3, 2'b01, 32'h0000_4010);
        tick();
        put(1, 2'b10, 32'h0000_4004);
        tick();
        // own store keeps own reservation; failing stcx kills nobody
        put(2, 2'b01, 32'h0000_5000);
        tick();
        put(2, 2'b10, 32'h0000_5000);
        tick();
        put(3, 2'b11, 32'h0000_5000);
        tick();
        // passing stcx of another core kills the match
        put(3, 2'b01, 32'h0000_5008);
        tick();
        put(3, 2'b11, 32'h0000_5000);
        tick();

        // R6: same-cycle larx against foreign store
        cur_req = "R6";
        put(0, 2'b01, 32'h0000_6000); put(1, 2'b10, 32'h0000_6008);
        tick();
        put(0, 2'b01, 32'h0000_6000); put(1, 2'b10, 32'h0000_6020);
        tick();

        // R7: simultaneous stcx pair, lowest core wins
        cur_req = "R7";
        put(0, 2'b01, 32'h0000_7000); put(2, 2'b01, 32'h0000_7004);
        tick();
        put(0, 2'b11, 32'h0000_7000); put(2, 2'b11, 32'h0000_7000);
        tick();
        // same-cycle foreign store defeats the stcx
        put(0, 2'b01, 32'h0000_7000);
        tick();
        put(0, 2'b11, 32'h0000_7000); put(1, 2'b10, 32'h0000_7010);
        tick();

        // R8: idle cycle after a response returns strobes low
        cur_req = "R8";
        tick();

        // random mix over four granules on all cores
        cur_req = "R5";
        for (int k = 0; k < 2000; k++) begin
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 2) != 0)
                    put(i, 2'($urandom_range(0, 3)),
                        {25'd0, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31))});
            end
            tick();
        end

        // R9: reset mid-run clears everything
        cur_req = "R9";
        rst = 1'b1;
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_t[i] = '0; m_rv[i] = 1'b0; m_rp[i] = 1'b0;
        end
        tick();
        rst = 1'b0;
        tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule